// File: doc/BRIEF.md
# Boolean Carry Engine with Bit-Address Mapping

This block runs single-bit instructions of a small 8-bit controller core. An instruction hands it an 8-bit bit address and one of four operations. The block turns that bit address into the byte that holds the bit and the bit's position inside that byte. It then runs a two-cycle read-modify-write on the shared direct-address byte space, which holds the internal RAM and the special function registers.

Bit addresses below 80h fall in a dense window of sixteen RAM bytes starting at 20h. Bit addresses from 80h up select one bit of a register whose byte address is a multiple of eight. The block owns the carry flag, which is the single-bit accumulator. Carry is also bit 7 of the status byte at direct address D0h. Bit reads and bit writes of that position go through the carry register, and byte stores from the core to D0h are snooped so that carry follows them.

Top module: `bitacc_top`

## Requirements
- R1: During reset and on the first cycle after it, carry_o is 0, busy_o is 0, done_o is 0, mem_rd_o is 0 and mem_wr_o is 0.
- R2: A bit address below 80h reads byte 20h + addr[6:3]. The selected position is addr[2:0]. So bit address 67h is bit 7 of byte 2Ch.
- R3: A bit address of 80h or above reads byte (addr & F8h) at position addr[2:0]. So 80h is bit 0 of byte 80h, and D7h is bit 7 of byte D0h.
- R4: A start taken while idle gives one read cycle on the next cycle, with mem_rd_o high and busy_o high. The cycle after that is the write cycle, with done_o high for exactly that one cycle and busy_o still high. The block is idle on the following cycle. A start that arrives while busy is ignored.
- R5: Operation code 0 (load carry) sets carry to the selected bit and performs no write.
- R6: Operation code 1 (store carry) writes the byte back with the selected bit equal to carry. Every other bit keeps the value read.
- R7: Operation code 2 (set) and operation code 3 (clear) write the byte back with the selected bit forced to 1 or to 0. Every other bit keeps the value read.
- R8: When the byte is D0h, its bit 7 is taken from carry and not from the memory. A set, clear or store to bit address D7h updates carry when the write cycle completes.
- R9: A direct byte write (dir_wr_i) to address D0h loads carry from data bit 7 on that edge. Direct writes to any other address leave carry unchanged. If a bit operation that changes carry completes on the same edge, the bit operation's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a bit operation |
| op_i | input | 2 | Operation: 0 load carry, 1 store carry, 2 set, 3 clear |
| bit_addr_i | input | 8 | Bit address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Carry flag |
| mem_rd_o | output | 1 | Byte read strobe |
| mem_wr_o | output | 1 | Byte write strobe |
| mem_addr_o | output | 8 | Direct byte address |
| mem_wdata_o | output | 8 | Byte written back |
| mem_rdata_i | input | 8 | Byte read data, valid in the same cycle |
| dir_wr_i | input | 1 | Core byte write, snooped |
| dir_addr_i | input | 8 | Address of the core byte write |
| dir_wdata_i | input | 8 | Data of the core byte write |

## Verification
The hardest case to reach is a core byte store to D0h that lands on the same edge as a bit operation that changes carry. Random stimulus almost never lines these up. A directed sequence therefore drives the snooped write on exactly the write cycle of a load-carry operation, with the opposite value. The bit-7 overlay of the status byte is also rare under random stimulus, so directed set, clear and store operations at bit address D7h and at the other bits of byte D0h are mixed in with the seeded random operations.

// File: rtl/bitacc_pkg.sv
package bitacc_pkg;
    parameter int unsigned AW = 8;
    parameter int unsigned DW = 8;
    localparam int unsigned PW = $clog2(DW);
    localparam logic [AW-1:0] RAM_BASE = 8'h20;
    localparam logic [AW-1:0] PSW_ADDR = 8'hD0;
    localparam int unsigned CY_POS = 7;

    typedef enum logic [1:0] {
        OP_LOAD_C  = 2'd0,
        OP_STORE_C = 2'd1,
        OP_SET     = 2'd2,
        OP_CLR     = 2'd3
    } bop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;

    typedef struct packed {
        logic [AW-1:0] byte_addr;
        logic [PW-1:0] pos;
        logic          in_sfr;
    } bloc_t;

    function automatic bloc_t map_bit(input logic [AW-1:0] a);
        bloc_t r;
        r.in_sfr = a[AW-1];
        r.pos    = a[PW-1:0];
        if (r.in_sfr)
            r.byte_addr = {a[AW-1:PW], {PW{1'b0}}};
        else
            r.byte_addr = RAM_BASE + AW'(a >> PW);
        return r;
    endfunction
endpackage

// File: rtl/bitacc_decode.sv
module bitacc_decode
    import bitacc_pkg::*;
(
    input  logic [AW-1:0] bit_addr,
    output bloc_t         loc,
    output logic          is_psw
);
    always_comb begin
        loc    = map_bit(bit_addr);
        is_psw = (loc.byte_addr == PSW_ADDR);
    end
endmodule

// File: rtl/bitacc_alu.sv
module bitacc_alu
    import bitacc_pkg::*;
(
    input  bop_e          op,
    input  logic [DW-1:0] rbyte,
    input  logic [PW-1:0] pos,
    input  logic          is_psw,
    input  logic          carry,
    output logic          need_wr,
    output logic [DW-1:0] wbyte,
    output logic          carry_upd,
    output logic          carry_nxt
);
    logic [DW-1:0] mask;
    logic          bit_val;
    logic          new_bit;

    always_comb begin
        mask    = DW'(1) << pos;
        bit_val = rbyte[pos];
        need_wr = (op != OP_LOAD_C);
        unique case (op)
            OP_STORE_C: new_bit = carry;
            OP_SET:     new_bit = 1'b1;
            OP_CLR:     new_bit = 1'b0;
            default:    new_bit = bit_val;
        endcase
        wbyte = new_bit ? (rbyte | mask) : (rbyte & ~mask);
        if (op == OP_LOAD_C) begin
            carry_upd = 1'b1;
            carry_nxt = bit_val;
        end else if (is_psw && (pos == PW'(CY_POS))) begin
            carry_upd = 1'b1;
            carry_nxt = new_bit;
        end else begin
            carry_upd = 1'b0;
            carry_nxt = carry;
        end
    end

    always_comb begin
        assert ((((wbyte ^ rbyte) & ~mask) == '0) || !need_wr)
            else $error("AST_RMW_OTHER_BITS");   // R6
    end
endmodule

// File: rtl/bitacc_top.sv
module bitacc_top
    import bitacc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic [AW-1:0] bit_addr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          carry_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    input  logic          dir_wr_i,
    input  logic [AW-1:0] dir_addr_i,
    input  logic [DW-1:0] dir_wdata_i
);
    st_e           st_q;
    bop_e          op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] byte_q;
    logic          carry_q;
    logic [DW-1:0] rd_merged;
    bloc_t         loc;
    logic          is_psw;
    logic          need_wr;
    logic [DW-1:0] wbyte;
    logic          carry_upd;
    logic          carry_nxt;

    bitacc_decode u_dec (
        .bit_addr (addr_q),
        .loc      (loc),
        .is_psw   (is_psw)
    );

    bitacc_alu u_alu (
        .op        (op_q),
        .rbyte     (byte_q),
        .pos       (loc.pos),
        .is_psw    (is_psw),
        .carry     (carry_q),
        .need_wr   (need_wr),
        .wbyte     (wbyte),
        .carry_upd (carry_upd),
        .carry_nxt (carry_nxt)
    );

    always_comb begin
        rd_merged = mem_rdata_i;
        if (is_psw)
            rd_merged[CY_POS] = carry_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            op_q    <= OP_LOAD_C;
            addr_q  <= '0;
            byte_q  <= '0;
            carry_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    st_q   <= ST_READ;
                    op_q   <= bop_e'(op_i);
                    addr_q <= bit_addr_i;
                end
                ST_READ: begin
                    byte_q <= rd_merged;
                    st_q   <= ST_WRITE;
                end
                default: st_q <= ST_IDLE;
            endcase
            if (st_q == ST_WRITE && carry_upd)
                carry_q <= carry_nxt;
            else if (dir_wr_i && dir_addr_i == PSW_ADDR)
                carry_q <= dir_wdata_i[CY_POS];
        end
    end

    assign busy_o      = (st_q != ST_IDLE);
    assign done_o      = (st_q == ST_WRITE);
    assign carry_o     = carry_q;
    assign mem_rd_o    = (st_q == ST_READ);
    assign mem_wr_o    = (st_q == ST_WRITE) && need_wr;
    assign mem_addr_o  = loc.byte_addr;
    assign mem_wdata_o = wbyte;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!busy_o && !carry_o && !mem_wr_o))
        else $error("AST_RESET_QUIET");                           // R1
    AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && !loc.in_sfr) |-> (mem_addr_o[AW-1:PW+1] == RAM_BASE[AW-1:PW+1]))
        else $error("AST_RAM_WINDOW");                            // R2
    AST_SFR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && loc.in_sfr) |-> (mem_addr_o[PW-1:0] == '0))
        else $error("AST_SFR_ALIGN");                             // R3
    AST_DONE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |=> (done_o && !mem_rd_o))
        else $error("AST_DONE_FOLLOWS_READ");                     // R4
    AST_NO_DOUBLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o))
        else $error("AST_NO_DOUBLE_ACCESS");                      // R4
    AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (done_o && op_q == OP_LOAD_C) |-> !mem_wr_o)
        else $error("AST_LOAD_NO_WRITE");                         // R5
    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!done_o && !(dir_wr_i && dir_addr_i == PSW_ADDR)) |=> $stable(carry_o))
        else $error("AST_CARRY_HOLD");                            // R9
endmodule

// File: tb/bitacc_top_tb_top.sv
module bitacc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic [1:0] op_i;
    logic [7:0] bit_addr_i;
    logic       busy_o, done_o, carry_o, mem_rd_o, mem_wr_o;
    logic [7:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic       dir_wr_i;
    logic [7:0] dir_addr_i, dir_wdata_i;

    logic [7:0] mem [256];
    int n_run = 0;
    int n_fail = 0;
    logic carry_m = 1'b0;

    always #4 clk = ~clk;

    bitacc_top dut_i (.*);

    assign mem_rdata_i = mem[mem_addr_o];
    always @(posedge clk) begin
        if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
        if (dir_wr_i) mem[dir_addr_i] <= dir_wdata_i;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        return a[7] ? (a & 8'hF8) : (8'h20 + {4'h0, a[6:3]});
    endfunction

    task automatic do_op(input logic [1:0] op, input logic [7:0] a);
        logic [7:0] b, rb, wb;
        logic bv, nb;
        b = exp_byte(a);
        @(negedge clk);
        start_i = 1; op_i = op; bit_addr_i = a;
        @(negedge clk);
        start_i = 0;
        rb = mem[b];
        if (b == 8'hD0) rb[7] = carry_m;
        bv = rb[a[2:0]];
        nb = (op == 2'd1) ? carry_m : (op == 2'd2) ? 1'b1 : (op == 2'd3) ? 1'b0 : bv;
        wb = rb;
        wb[a[2:0]] = nb;
        chk(mem_rd_o && busy_o, "R4", {busy_o, mem_rd_o}, 3);
        chk(mem_addr_o == b, a[7] ? "R3" : "R2", mem_addr_o, b);
        @(negedge clk);
        chk(done_o && busy_o && !mem_rd_o, "R4", {done_o, busy_o}, 3);
        if (op == 2'd0) begin
            chk(!mem_wr_o, "R5", mem_wr_o, 0);
            carry_m = bv;
        end else begin
            chk(mem_wr_o && mem_wdata_o == wb, (op == 2'd1) ? "R6" : "R7", mem_wdata_o, wb);
            if (b == 8'hD0 && a[2:0] == 3'd7) carry_m = nb;
        end
        @(negedge clk);
        chk(!done_o && !busy_o, "R4", {done_o, busy_o}, 0);
        chk(carry_o == carry_m, (op == 2'd0) ? "R5" : "R8", carry_o, carry_m);
    endtask

    task automatic dir_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        dir_wr_i = 1; dir_addr_i = a; dir_wdata_i = d;
        @(negedge clk);
        dir_wr_i = 0;
        if (a == 8'hD0) carry_m = d[7];
        chk(carry_o == carry_m, "R9", carry_o, carry_m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] a, b, keep;
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        rst = 1; start_i = 0; op_i = 0; bit_addr_i = 0;
        dir_wr_i = 0; dir_addr_i = 0; dir_wdata_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy_o && !done_o && !carry_o && !mem_rd_o && !mem_wr_o, "R1",
            {busy_o, done_o, carry_o, mem_rd_o, mem_wr_o}, 0);
        rst = 0;
        @(negedge clk);
        chk(!busy_o && !done_o && !carry_o && !mem_rd_o && !mem_wr_o, "R1",
            {busy_o, done_o, carry_o, mem_rd_o, mem_wr_o}, 0);

        // R2 / R3 directed mapping corners
        mem[8'h2C] = 8'h80;
        do_op(2'd0, 8'h67);
        chk(carry_o == 1'b1, "R2", carry_o, 1);
        mem[8'h80] = 8'hFE;
        do_op(2'd0, 8'h80);
        chk(carry_o == 1'b0, "R3", carry_o, 0);
        do_op(2'd2, 8'h00);
        do_op(2'd3, 8'h7F);
        do_op(2'd1, 8'hFF);

        // R8 status byte overlay
        mem[8'hD0] = 8'h00;
        do_op(2'd2, 8'hD7);
        chk(carry_o == 1'b1, "R8", carry_o, 1);
        do_op(2'd2, 8'hD3);
        chk(mem[8'hD0] == 8'h88, "R8", mem[8'hD0], 8'h88);
        do_op(2'd3, 8'hD7);
        do_op(2'd0, 8'hD7);
        chk(carry_o == 1'b0, "R8", carry_o, 0);

        // R9 snooped byte writes
        dir_write(8'hD0, 8'h80);
        dir_write(8'hD8, 8'h00);
        dir_write(8'hD0, 8'h7F);

        // R9 conflict: load carry completes on the same edge as a status write
        mem[8'h21] = 8'h01;
        @(negedge clk);
        start_i = 1; op_i = 2'd0; bit_addr_i = 8'h08;
        @(negedge clk);
        start_i = 0;
        @(negedge clk);
        dir_wr_i = 1; dir_addr_i = 8'hD0; dir_wdata_i = 8'h00;
        @(negedge clk);
        dir_wr_i = 0;
        carry_m = 1'b1;
        chk(carry_o == 1'b1, "R9", carry_o, 1);

        // R4 start while busy is ignored
        keep = mem[8'h90];
        @(negedge clk);
        start_i = 1; op_i = 2'd0; bit_addr_i = 8'h10;
        @(negedge clk);
        op_i = 2'd2; bit_addr_i = 8'h91;
        @(negedge clk);
        start_i = 0;
        @(negedge clk);
        chk(!busy_o && !mem_rd_o, "R4", {busy_o, mem_rd_o}, 0);
        chk(mem[8'h90] == keep, "R4", mem[8'h90], keep);
        carry_m = carry_o;

        // seeded random operations
        for (int i = 0; i < 400; i++) begin
            a = 8'($urandom);
            if ((i % 16) == 5) begin
                b = ($urandom % 2) ? 8'hD0 : 8'($urandom);
                dir_write(b, 8'($urandom));
            end else begin
                do_op(2'($urandom), a);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule